// File: doc/BRIEF.md
# Serial Memory Slave Front End

This block is the pin-side front end of a serial memory device that answers a host over SPI in clock modes 0 and 3. All pins are synchronised into the device's system clock. The block detects chip-select framing and the edges of the serial clock. It assembles incoming command, address and write bytes MSB first and hands each one to a command decoder with a one-cycle strobe. It also marks the start and the end of every frame.

For reads, the decoder raises an output enable and supplies bytes. It chooses single-line output, or dual-line output in which the serial input pin also drives data. The block serialises each byte on the falling edges of the serial clock and pulses a load strobe whenever it takes a new byte. An active-low pause input freezes the serial transfer at its current bit position. While the device is deselected or paused, the output enables stay low. An active-low protect input is synchronised and passed on as a lock flag.

Top module: `spi_mem_front`

## Requirements
- R1: A falling edge of `spi_cs_n` starts a frame: `frame_start` pulses for one cycle and the receive and transmit bit positions restart at bit 7. A rising edge of `spi_cs_n` pulses `frame_end`. A partial byte from an earlier frame never merges into the next frame.
- R2: While selected, `si_in` is sampled on every rising edge of `spi_sck`, MSB first. After each eighth sample, `rx_valid` pulses for exactly one cycle with the assembled byte on `rx_byte`.
- R3: While `spi_cs_n` is high, `si_in` and `spi_sck` have no effect: no `rx_valid`, and `so_oe` and `io0_oe` are low.
- R4: In single mode (`tx_dual`=0, `tx_en`=1), each falling edge of `spi_sck` presents the next bit of the byte on `so_out`, bit 7 first, and `io0_oe` stays low.
- R5: In dual mode (`tx_dual`=1), each falling edge presents two bits: the upper bit of the pair on `so_out` and the lower bit on `io0_out`, with `io0_oe` high. One byte takes four falling edges, bits 7:6 first.
- R6: `tx_load` pulses for one cycle each time a byte is taken from `tx_byte`, which happens on the first falling edge of each output byte while `tx_en` is high.
- R7: A pause (`spi_hold_n`=0) takes effect only while selected and while `spi_sck` is low. If `spi_hold_n` falls while `spi_sck` is high, outputs stay enabled until the clock goes low.
- R8: While paused, `so_oe` and `io0_oe` are low and edges on `spi_sck` and data on `si_in` are ignored.
- R9: Leaving the pause resumes both the receive and the transmit shift at the exact bit where they stopped.
- R10: `wp_lock` is high exactly when the synchronised `spi_wp_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from host |
| spi_hold_n | input | 1 | Pause request, active low |
| spi_wp_n | input | 1 | Write protect, active low |
| si_in | input | 1 | Serial data in (IO0 input side) |
| so_out | output | 1 | Serial data out (IO1), upper bit in dual mode |
| so_oe | output | 1 | Output enable for `so_out` |
| io0_out | output | 1 | IO0 data out, lower bit in dual mode |
| io0_oe | output | 1 | Output enable for `io0_out` |
| frame_start | output | 1 | One-cycle pulse at chip-select assertion |
| frame_end | output | 1 | One-cycle pulse at chip-select release |
| rx_byte | output | DW | Last assembled input byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_byte` |
| tx_en | input | 1 | Decoder enables read output |
| tx_dual | input | 1 | 1 selects two-line output |
| tx_byte | input | DW | Next byte to transmit |
| tx_load | output | 1 | One-cycle pulse when `tx_byte` is taken |
| wp_lock | output | 1 | High while protection is asserted |

## Verification
The bound checker watches, on every cycle, that outputs are enabled only after chip select has been low for the synchronisation delay. It also checks that a pause begins only with the clock low and the device selected, that the bit counters stay frozen during a pause, that a frame start finds both counters at zero, and that the receive strobe never lasts two cycles. The bench scenarios are the only way to show the actual byte values and bit order in single and dual reads. They are also what shows that a byte split by a pause reassembles correctly, that a truncated frame leaves no residue, and that stimulus on deselected pins changes nothing at the decoder side.

// File: rtl/spi_mem_front.sv
`timescale 1ns/1ps
module spi_mem_front #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_cs_n,
  input  logic          spi_sck,
  input  logic          spi_hold_n,
  input  logic          spi_wp_n,
  input  logic          si_in,
  output logic          so_out,
  output logic          so_oe,
  output logic          io0_out,
  output logic          io0_oe,
  output logic          frame_start,
  output logic          frame_end,
  output logic [DW-1:0] rx_byte,
  output logic          rx_valid,
  input  logic          tx_en,
  input  logic          tx_dual,
  input  logic [DW-1:0] tx_byte,
  output logic          tx_load,
  output logic          wp_lock
);
  localparam int CW = $clog2(DW);
  localparam logic [CW:0] WRAP = (CW+1)'(DW);

  logic [2:0]    cs_r, sck_r;
  logic [1:0]    hold_r, wp_r, si_r;
  logic          hold_q, dual_q;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic [DW-2:0] rx_sh;
  logic [DW-1:0] tx_sh;
  logic [CW:0]   tx_nxt;
  logic          cs_s, sck_s, cs_fall, cs_rise, sck_rise, sck_fall, live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_r   <= 3'b111;
      sck_r  <= 3'b000;
      hold_r <= 2'b11;
      wp_r   <= 2'b11;
      si_r   <= 2'b00;
    end else begin
      cs_r   <= {cs_r[1:0], spi_cs_n};
      sck_r  <= {sck_r[1:0], spi_sck};
      hold_r <= {hold_r[0], spi_hold_n};
      wp_r   <= {wp_r[0], spi_wp_n};
      si_r   <= {si_r[0], si_in};
    end
  end

  assign cs_s     = cs_r[1];
  assign sck_s    = sck_r[1];
  assign cs_fall  = cs_r[2] & ~cs_r[1];
  assign cs_rise  = ~cs_r[2] & cs_r[1];
  assign sck_rise = ~sck_r[2] & sck_r[1];
  assign sck_fall = sck_r[2] & ~sck_r[1];
  assign live     = ~cs_s & ~hold_q;
  assign wp_lock  = ~wp_r[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 hold_q <= 1'b0;
    else if (cs_s | hold_r[1])  hold_q <= 1'b0;
    else if (!sck_s)            hold_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_cnt      <= '0;
      rx_sh       <= '0;
      rx_byte     <= '0;
      rx_valid    <= 1'b0;
      frame_start <= 1'b0;
      frame_end   <= 1'b0;
    end else begin
      rx_valid    <= 1'b0;
      frame_start <= cs_fall;
      frame_end   <= cs_rise;
      if (cs_fall) begin
        rx_cnt <= '0;
      end else if (live && sck_rise) begin
        rx_sh <= {rx_sh[DW-3:0], si_r[1]};
        if (rx_cnt == CW'(DW-1)) begin
          rx_cnt   <= '0;
          rx_byte  <= {rx_sh, si_r[1]};
          rx_valid <= 1'b1;
        end else begin
          rx_cnt <= rx_cnt + 1'b1;
        end
      end
    end
  end

  assign tx_nxt = {1'b0, tx_cnt} + (dual_q ? (CW+1)'(2) : (CW+1)'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_cnt  <= '0;
      tx_sh   <= '0;
      dual_q  <= 1'b0;
      tx_load <= 1'b0;
    end else begin
      tx_load <= 1'b0;
      if (cs_fall) begin
        tx_cnt <= '0;
        dual_q <= 1'b0;
      end else if (live && tx_en && sck_fall) begin
        if (tx_cnt == '0) begin
          tx_sh   <= tx_byte;
          dual_q  <= tx_dual;
          tx_load <= 1'b1;
          tx_cnt  <= tx_dual ? CW'(2) : CW'(1);
        end else begin
          tx_sh  <= dual_q ? {tx_sh[DW-3:0], 2'b00} : {tx_sh[DW-2:0], 1'b0};
          tx_cnt <= (tx_nxt == WRAP) ? '0 : tx_nxt[CW-1:0];
        end
      end
    end
  end

  assign so_out  = tx_sh[DW-1];
  assign io0_out = tx_sh[DW-2];
  assign so_oe   = live & tx_en;
  assign io0_oe  = so_oe & dual_q;
endmodule

// File: rtl/spi_mem_front_chk.sv
`timescale 1ns/1ps
module spi_mem_front_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          spi_cs_n,
  input logic          so_oe,
  input logic          io0_oe,
  input logic          rx_valid,
  input logic          frame_start,
  input logic          hold_q,
  input logic          sck_s,
  input logic          cs_s,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_cnt
);
  AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> !$past(spi_cs_n, 2)); // R3
  AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R2
  AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> $past(!sck_s && !cs_s)); // R7
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && $past(hold_q)) |-> ($stable(rx_cnt) && $stable(tx_cnt))); // R9
  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (rx_cnt == '0 && tx_cnt == '0)); // R1
  AST_DUAL_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    io0_oe |-> !tx_cnt[0]); // R5
endmodule

bind spi_mem_front spi_mem_front_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .so_oe(so_oe),
  .io0_oe(io0_oe), .rx_valid(rx_valid), .frame_start(frame_start),
  .hold_q(hold_q), .sck_s(sck_s), .cs_s(cs_s), .rx_cnt(rx_cnt),
  .tx_cnt(tx_cnt)
);

// File: tb/spi_mem_front_bench.sv
`timescale 1ns/1ps
module spi_mem_front_bench;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_hold_n = 1'b1, spi_wp_n = 1'b1, si_in = 1'b0;
  logic tx_en = 1'b0, tx_dual = 1'b0;
  logic [7:0] tx_byte;
  logic so_out, so_oe, io0_out, io0_oe, frame_start, frame_end, rx_valid, tx_load, wp_lock;
  logic [7:0] rx_byte;

  spi_mem_front u_spi_mem_front (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_hold_n(spi_hold_n), .spi_wp_n(spi_wp_n), .si_in(si_in),
    .so_out(so_out), .so_oe(so_oe), .io0_out(io0_out), .io0_oe(io0_oe),
    .frame_start(frame_start), .frame_end(frame_end), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .tx_en(tx_en), .tx_dual(tx_dual), .tx_byte(tx_byte),
    .tx_load(tx_load), .wp_lock(wp_lock)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  int fs_cnt = 0, fe_cnt = 0, ld_cnt = 0, tidx = 0, hi_cnt = 0;
  logic [7:0] txq [8];
  logic [7:0] rxq [$];
  logic s_so, s_io, s_soe, s_ioe;

  assign tx_byte = txq[tidx[2:0]];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) rxq.push_back(rx_byte);
      if (frame_start) fs_cnt++;
      if (frame_end) fe_cnt++;
      if (tx_load) begin ld_cnt++; tidx++; end
      if (spi_cs_n) hi_cnt++; else hi_cnt = 0;
      if (hi_cnt >= 4) chk("R3 idle outputs", {so_oe, io0_oe, rx_valid}, 0);
    end
  end

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic d);
    spi_sck = 1'b0; si_in = d;
    waitc(H);
    s_so = so_out; s_io = io0_out; s_soe = so_oe; s_ioe = io0_oe;
    spi_sck = 1'b1;
    waitc(H);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) xfer(b[i]);
  endtask

  task automatic finish_sim;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    logic [15:0] got;
    int bad;
    waitc(5);
    rst_n = 1'b1;
    waitc(3);
    chk("R3 reset oe", {so_oe, io0_oe}, 0);
    chk("R2 reset rx_valid", rx_valid, 0);
    chk("R10 reset wp_lock", wp_lock, 0);

    // R2 mode 0 byte assembly, R1 framing
    spi_cs_n = 1'b0; waitc(H);
    send_byte(8'hA5); send_byte(8'h3C);
    spi_sck = 1'b0; waitc(H); spi_cs_n = 1'b1; waitc(H);
    chk("R2 byte count", rxq.size(), 2);
    if (rxq.size() == 2) begin
      chk("R2 first byte", rxq[0], 8'hA5);
      chk("R2 second byte", rxq[1], 8'h3C);
    end
    chk("R1 frame_start", fs_cnt, 1);
    chk("R1 frame_end", fe_cnt, 1);

    // R3 deselected stimulus ignored
    rxq.delete(); tx_en = 1'b1; bad = 0;
    for (int i = 0; i < 16; i++) begin xfer(i[0]); if (s_soe || s_ioe) bad++; end
    spi_sck = 1'b0; tx_en = 1'b0; waitc(H);
    chk("R3 no rx while deselected", rxq.size(), 0);
    chk("R3 no oe while deselected", bad, 0);
    chk("R6 no load while deselected", ld_cnt, 0);

    // R1 truncated frame leaves no residue
    spi_cs_n = 1'b0; waitc(H);
    xfer(1); xfer(1); xfer(1);
    spi_sck = 1'b0; waitc(H); spi_cs_n = 1'b1; waitc(H);
    spi_cs_n = 1'b0; waitc(H);
    send_byte(8'h81);
    spi_sck = 1'b0; waitc(H); spi_cs_n = 1'b1; waitc(H);
    chk("R1 restart count", rxq.size(), 1);
    if (rxq.size() >= 1) chk("R1 restart byte", rxq[0], 8'h81);

    // R4 single read, R6 loads
    rxq.delete(); ld_cnt = 0;
    spi_cs_n = 1'b0; waitc(H);
    send_byte(8'h03);
    tidx = 0; txq[0] = 8'hC6; txq[1] = 8'h5A; tx_dual = 1'b0; tx_en = 1'b1;
    got = '0; bad = 0;
    for (int i = 0; i < 16; i++) begin xfer(0); got = {got[14:0], s_so}; if (!s_soe || s_ioe) bad++; end
    tx_en = 1'b0; waitc(H); spi_sck = 1'b0; waitc(H); spi_cs_n = 1'b1; waitc(H);
    chk("R2 command byte", rxq.size() > 0 ? int'(rxq[0]) : -1, 8'h03);
    chk("R4 single data", got, 16'hC65A);
    chk("R4 enables", bad, 0);
    chk("R6 load pulses", ld_cnt, 2);

    // R5 dual read in mode 3
    rxq.delete(); ld_cnt = 0;
    spi_sck = 1'b1; waitc(H);
    spi_cs_n = 1'b0; waitc(H);
    send_byte(8'h3B);
    tidx = 0; txq[0] = 8'h9D; txq[1] = 8'h42; tx_dual = 1'b1; tx_en = 1'b1;
    got = '0; bad = 0;
    for (int i = 0; i < 8; i++) begin xfer(0); got = {got[13:0], s_so, s_io}; if (!s_soe || !s_ioe) bad++; end
    tx_en = 1'b0; tx_dual = 1'b0; waitc(H); spi_cs_n = 1'b1; waitc(H);
    spi_sck = 1'b0; waitc(H);
    chk("R2 mode 3 command", rxq.size() > 0 ? int'(rxq[0]) : -1, 8'h3B);
    chk("R5 dual data", got, 16'h9D42);
    chk("R5 dual enables", bad, 0);
    chk("R6 dual loads", ld_cnt, 2);

    // R8 R9 receive paused mid byte
    rxq.delete();
    spi_cs_n = 1'b0; waitc(H);
    xfer(1); xfer(0); xfer(1);
    spi_sck = 1'b0; waitc(H);
    spi_hold_n = 1'b0; waitc(H);
    for (int i = 0; i < 3; i++) begin
      si_in = 1'b1; spi_sck = 1'b1; waitc(H); spi_sck = 1'b0; waitc(H);
    end
    chk("R8 no rx during pause", rxq.size(), 0);
    spi_hold_n = 1'b1; waitc(H);
    xfer(1); xfer(0); xfer(1); xfer(0); xfer(0);
    spi_sck = 1'b0; waitc(H); spi_cs_n = 1'b1; waitc(H);
    chk("R9 resumed byte count", rxq.size(), 1);
    if (rxq.size() >= 1) chk("R9 resumed byte", rxq[0], 8'hB4);

    // R7 R8 R9 pause during single read
    spi_cs_n = 1'b0; waitc(H);
    send_byte(8'h0B);
    tidx = 0; txq[0] = 8'hA5; tx_en = 1'b1;
    got = '0;
    for (int i = 0; i < 4; i++) begin xfer(0); got = {got[14:0], s_so}; end
    spi_hold_n = 1'b0; waitc(6);
    chk("R7 no pause while clock high", so_oe, 1);
    spi_sck = 1'b0; waitc(6);
    chk("R8 outputs off in pause", {so_oe, io0_oe}, 0);
    for (int i = 0; i < 2; i++) begin
      spi_sck = 1'b1; waitc(H); spi_sck = 1'b0; waitc(H);
    end
    chk("R8 still off in pause", so_oe, 0);
    spi_hold_n = 1'b1; waitc(H);
    chk("R9 oe back after pause", so_oe, 1);
    got = {got[14:0], so_out};
    spi_sck = 1'b1; waitc(H);
    for (int i = 0; i < 3; i++) begin xfer(0); got = {got[14:0], s_so}; end
    tx_en = 1'b0; waitc(H); spi_sck = 1'b0; waitc(H); spi_cs_n = 1'b1; waitc(H);
    chk("R9 read resumed at paused bit", got[7:0], 8'hA5);

    // R10 protect flag
    spi_wp_n = 1'b0; waitc(4);
    chk("R10 lock on", wp_lock, 1);
    spi_wp_n = 1'b1; waitc(4);
    chk("R10 lock off", wp_lock, 0);

    finish_sim();
  end
endmodule